// File: doc/BRIEF.md
# In-Order Retirement Buffer with Branch Tags

This block records every in-flight instruction in program order, from the cycle it is dispatched until the cycle it retires. It is a ring of slots with a head pointer and an occupancy count. Each slot stores a rename-register number, an architectural destination, a store flag, a completion bit and a mask of unresolved branches the instruction depends on. A slot's ring index is its tag. The completion port uses that tag to mark the instruction finished.

Dispatch delivers a group of up to four instructions per cycle. Lanes 0 to `disp_num-1` are valid, and lane 0 is the oldest. At the head, the block releases up to four entries per cycle that are finished and no longer speculative. For each released entry it presents the rename register, the architectural destination and the store flag. The consumer uses these to copy the rename register into the architectural register file, return the rename register to the free pool and let a buffered store go to memory.

A branch-resolution port names one of the branch tags. A correct resolution clears that bit in every entry, and the tag may then be reused. A mispredict removes every entry carrying the bit, pulls the tail back, and reports the removed entries' rename registers as a bit vector in the same cycle.

Top module: `retire_queue`

## Requirements
- R1: The buffer holds at most 16 entries, and `disp_ready` is low whenever the free slot count is below `disp_num`.
- R2: A dispatch group is taken whole or not at all. When `disp_ready` is high and `disp_num` is nonzero, lane i is written to slot `(disp_tag + i) mod 16`, where `disp_tag` is the current tail slot. A stalled group changes nothing.
- R3: `ret_valid` is a contiguous run starting at lane 0, with at most 4 lanes. Lane k is the k-th oldest entry. The run stops at the first entry that cannot retire, even if younger entries are ready. Released entries leave the head at the next clock edge.
- R4: An entry can retire only when it has been marked complete and its branch mask is all zero.
- R5: For every valid retire lane k, `ret_preg` bits [4k+3:4k] carry the entry's rename register and `ret_areg` bits [5k+4:5k] carry its architectural destination. The consumer treats the pair as a commit plus a rename-register free.
- R6: `ret_store[k]` is high only when `ret_valid[k]` is high and the entry was dispatched with its store flag set. This is the release of a buffered store.
- R7: When `br_valid` and `br_miss` are both high, every entry whose mask bit `br_id` is set is removed at the next clock edge, and the tail returns to just after the youngest surviving entry. In the same cycle, `flush_free` has bit n set for every removed entry whose rename register is n. Otherwise `flush_free` is zero.
- R8: When `br_valid` is high and `br_miss` is low, mask bit `br_id` is cleared in every stored entry at the next clock edge.
- R9: A completion with `cmp_valid` high marks the live entry at slot `cmp_tag` complete. A completion that names an empty slot has no effect: an instruction later dispatched into that slot still waits for its own completion.
- R10: After reset the buffer is empty, `disp_tag` is 0, `disp_ready` is high for any group of 4 or fewer, `ret_valid` is 0 and `flush_free` is 0.
- R11: In a cycle with a mispredict, `disp_ready` is low and no group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_num | input | 3 | Number of valid dispatch lanes, 0 to 4 |
| disp_preg | input | 16 | Rename register per lane, 4 bits each |
| disp_areg | input | 20 | Architectural destination per lane, 5 bits each |
| disp_store | input | 4 | Store flag per lane |
| disp_bmask | input | 16 | Branch-dependency mask per lane, 4 bits each |
| disp_ready | output | 1 | The whole group fits and no flush is in progress |
| disp_tag | output | 4 | Slot (tag) assigned to lane 0 |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 4 | Slot being marked complete |
| br_valid | input | 1 | Branch-resolution strobe |
| br_miss | input | 1 | 1 = mispredict (flush), 0 = correct (clear) |
| br_id | input | 2 | Branch tag being resolved |
| ret_valid | output | 4 | Retire lanes, contiguous from lane 0 |
| ret_preg | output | 16 | Rename register per retire lane |
| ret_areg | output | 20 | Architectural destination per retire lane |
| ret_store | output | 4 | Store release per retire lane |
| flush_free | output | 12 | Rename registers freed by a mispredict, one bit per register |

## Verification
The inline assertions check the following on every cycle:
- occupancy stays within 16;
- a stalled group leaves occupancy unchanged apart from retirement;
- retire lanes form a contiguous run;
- the head entry is complete and non-speculative whenever lane 0 retires;
- a mispredict never grows the buffer and always blocks dispatch.

Only the bench's scenarios can show the rest. These are the actual values on the commit and store lanes, the exact set of rename registers freed by a flush, tag reuse after the tail moves back, the stop at an incomplete entry in front of finished ones, and completions aimed at empty slots. The bench's cycle-by-cycle model compares all of these against the block.

// File: rtl/rq_pkg.sv
// Shared types for the retirement buffer.
package rq_pkg;

    // Action requested on the branch-resolution port in the current cycle.
    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_CLEAR = 2'd1,
        BR_FLUSH = 2'd2
    } br_act_e;

endpackage

// File: rtl/rq_slot_gate.sv
// Dispatch admission. A group is admitted only when all of its lanes fit
// in the free slots and no flush is in progress this cycle.
// Assumes: num above LANES is malformed and is refused.
module rq_slot_gate #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int DN_W  = $clog2(LANES + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [DN_W-1:0]  num,
    input  logic             flush,
    output logic             ready,
    output logic             accept
);
    logic [CNT_W-1:0] free_slots;

    // Compare the group size with the free space.
    always_comb begin
        free_slots = CNT_W'(DEPTH) - count;
        ready      = !flush && (CNT_W'(num) <= free_slots) && (int'(num) <= LANES);
        accept     = ready && (num != '0);
    end
endmodule

// File: rtl/rq_retire_pick.sv
// Picks the retiring lanes: the longest run of ready entries starting at
// the oldest one, capped at LANES.
// Assumes: rdy[k] already includes the liveness of age position k.
module rq_retire_pick #(
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] rdy,
    output logic [LANES-1:0] take,
    output logic [CW-1:0]    n
);
    logic blocked;

    // Walk from the oldest lane and stop at the first one that is not ready.
    always_comb begin
        take    = '0;
        n       = '0;
        blocked = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (!blocked && rdy[k]) begin
                take[k] = 1'b1;
                n       = n + CW'(1);
            end else begin
                blocked = 1'b1;
            end
        end
    end

    for (genvar k = 1; k < LANES; k++) begin : g_chk
        AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            take[k] |-> take[k-1]); // R3
    end
endmodule

// File: rtl/rq_flush_scan.sv
// Finds where a flush cuts the buffer. Positions are in age order, with 0
// at the head. keep is the position of the oldest hit entry, or count when
// nothing hits. kill marks the live positions from keep onward.
// Assumes: the entries carrying a branch's bit are contiguous at the tail.
module rq_flush_scan #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] keep,
    output logic [DEPTH-1:0] kill
);
    logic found;

    // Locate the oldest tagged entry.
    always_comb begin
        keep  = count;
        found = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            if (!found && hit[a]) begin
                keep  = CNT_W'(a);
                found = 1'b1;
            end
        end
    end

    // Mark every live position from the cut point to the tail.
    always_comb begin
        for (int a = 0; a < DEPTH; a++) begin
            kill[a] = (CNT_W'(a) >= keep) && (CNT_W'(a) < count);
        end
    end
endmodule

// File: rtl/retire_queue.sv
// In-order retirement buffer with branch-dependency masks.
// Holds up to DEPTH entries in a ring (head + count). Each entry carries a
// rename register, an architectural destination, a store flag, a completion
// bit and a branch mask. Entries retire from the head, up to RET_W per
// cycle. A mispredict trims the tail, and a correct resolution clears a
// mask bit everywhere.
// Assumes: DEPTH is a power of two; entries tagged by a branch are younger
// than every untagged entry; at most one completion per cycle.
module retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DISP_W   = 4,
    parameter int RET_W    = 4,
    parameter int NUM_PREG = 12,
    parameter int AREG_W   = 5,
    parameter int NUM_BR   = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1,
    localparam int PREG_W = $clog2(NUM_PREG),
    localparam int BR_W   = (NUM_BR > 1) ? $clog2(NUM_BR) : 1,
    localparam int DN_W   = $clog2(DISP_W + 1),
    localparam int RN_W   = $clog2(RET_W + 1),
    localparam int LN_W   = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DN_W-1:0]            disp_num,
    input  logic [DISP_W*PREG_W-1:0]   disp_preg,
    input  logic [DISP_W*AREG_W-1:0]   disp_areg,
    input  logic [DISP_W-1:0]          disp_store,
    input  logic [DISP_W*NUM_BR-1:0]   disp_bmask,
    output logic                       disp_ready,
    output logic [IDX_W-1:0]           disp_tag,
    input  logic                       cmp_valid,
    input  logic [IDX_W-1:0]           cmp_tag,
    input  logic                       br_valid,
    input  logic                       br_miss,
    input  logic [BR_W-1:0]            br_id,
    output logic [RET_W-1:0]           ret_valid,
    output logic [RET_W*PREG_W-1:0]    ret_preg,
    output logic [RET_W*AREG_W-1:0]    ret_areg,
    output logic [RET_W-1:0]           ret_store,
    output logic [NUM_PREG-1:0]        flush_free
);
    // Ring state
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  count_q;

    // Entry storage
    logic [DEPTH-1:0]  e_done;
    logic [DEPTH-1:0]  e_store;
    logic [NUM_BR-1:0] e_mask [DEPTH];
    logic [PREG_W-1:0] e_preg [DEPTH];
    logic [AREG_W-1:0] e_areg [DEPTH];

    br_act_e           br_act;
    logic [IDX_W-1:0]  tail;
    logic              accept;
    logic [DEPTH-1:0]  age_hit;
    logic [DEPTH-1:0]  age_kill;
    logic [CNT_W-1:0]  keep;
    logic [CNT_W-1:0]  count_base;
    logic [RET_W-1:0]  age_rdy;
    logic [RN_W-1:0]   ret_n;
    logic              cmp_live;
    logic [DEPTH-1:0]  wr_en;
    logic [LN_W-1:0]   wr_lane [DEPTH];

    // Decode the branch-resolution port into one action.
    always_comb begin
        if (!br_valid)    br_act = BR_IDLE;
        else if (br_miss) br_act = BR_FLUSH;
        else              br_act = BR_CLEAR;
    end

    assign tail     = head_q + count_q[IDX_W-1:0];
    assign disp_tag = tail;

    // Age-ordered view used by the flush scan.
    for (genvar a = 0; a < DEPTH; a++) begin : g_age
        logic [IDX_W-1:0] phys;
        assign phys       = head_q + IDX_W'(a);
        assign age_hit[a] = (CNT_W'(a) < count_q) && e_mask[phys][br_id];
    end

    // Retire lanes: the oldest RET_W entries and their outputs.
    for (genvar k = 0; k < RET_W; k++) begin : g_lane
        logic [IDX_W-1:0] phys;
        assign phys       = head_q + IDX_W'(k);
        assign age_rdy[k] = (CNT_W'(k) < count_q) && e_done[phys] && (e_mask[phys] == '0);
        assign ret_preg[k*PREG_W +: PREG_W] = e_preg[phys];
        assign ret_areg[k*AREG_W +: AREG_W] = e_areg[phys];
        assign ret_store[k] = ret_valid[k] && e_store[phys];
    end

    rq_slot_gate #(.DEPTH(DEPTH), .LANES(DISP_W)) u_gate (
        .count  (count_q),
        .num    (disp_num),
        .flush  (br_act == BR_FLUSH),
        .ready  (disp_ready),
        .accept (accept)
    );

    rq_retire_pick #(.LANES(RET_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy   (age_rdy),
        .take  (ret_valid),
        .n     (ret_n)
    );

    rq_flush_scan #(.DEPTH(DEPTH)) u_scan (
        .hit   (age_hit),
        .count (count_q),
        .keep  (keep),
        .kill  (age_kill)
    );

    // Build the freed-register vector from the killed entries.
    always_comb begin
        flush_free = '0;
        if (br_act == BR_FLUSH) begin
            for (int a = 0; a < DEPTH; a++) begin
                for (int r = 0; r < NUM_PREG; r++) begin
                    if (age_kill[a] && (e_preg[head_q + IDX_W'(a)] == PREG_W'(r)))
                        flush_free[r] = 1'b1;
                end
            end
        end
    end

    // Map each accepted dispatch lane onto its ring slot.
    always_comb begin
        for (int p = 0; p < DEPTH; p++) begin
            wr_en[p]   = 1'b0;
            wr_lane[p] = '0;
            for (int l = 0; l < DISP_W; l++) begin
                if (accept && (DN_W'(l) < disp_num) && ((tail + IDX_W'(l)) == IDX_W'(p))) begin
                    wr_en[p]   = 1'b1;
                    wr_lane[p] = LN_W'(l);
                end
            end
        end
    end

    // A completion only counts when its slot holds a live entry.
    assign cmp_live   = (CNT_W'(IDX_W'(cmp_tag - head_q)) < count_q);
    assign count_base = (br_act == BR_FLUSH) ? keep : count_q;

    // Advance the head by the retired entries and resize for flush and dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + IDX_W'(ret_n);
            count_q <= count_base - CNT_W'(ret_n) + (accept ? CNT_W'(disp_num) : '0);
        end
    end

    // Per-slot update: clear a mask bit, record completion, write dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < DEPTH; p++) begin
                e_done[p]  <= 1'b0;
                e_store[p] <= 1'b0;
                e_mask[p]  <= '0;
                e_preg[p]  <= '0;
                e_areg[p]  <= '0;
            end
        end else begin
            for (int p = 0; p < DEPTH; p++) begin
                if (br_act == BR_CLEAR)
                    e_mask[p][br_id] <= 1'b0;
                if (cmp_valid && cmp_live && (cmp_tag == IDX_W'(p)))
                    e_done[p] <= 1'b1;
                if (wr_en[p]) begin
                    e_done[p]  <= 1'b0;
                    e_store[p] <= disp_store[wr_lane[p]];
                    e_mask[p]  <= disp_bmask[wr_lane[p]*NUM_BR +: NUM_BR];
                    e_preg[p]  <= disp_preg[wr_lane[p]*PREG_W +: PREG_W];
                    e_areg[p]  <= disp_areg[wr_lane[p]*AREG_W +: AREG_W];
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R1

    AST_STALL_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_num != '0 && !disp_ready && br_act != BR_FLUSH)
        |=> count_q == $past(count_q) - CNT_W'($past(ret_n))); // R2

    AST_RET_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[0] |-> (e_done[head_q] && e_mask[head_q] == '0 && count_q != '0)); // R4

    AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (br_act == BR_FLUSH) |=> count_q <= $past(count_q)); // R7

    AST_FLUSH_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_miss) |-> !disp_ready); // R11
endmodule

// File: tb/retire_queue_test.sv
// Bench for retire_queue: a behavioural queue model is compared on every cycle.
module retire_queue_test;
    localparam int DEPTH = 16, DW = 4, RW = 4, PW = 4, AW = 5, NB = 4, NPREG = 12, IW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst_n;
    logic [2:0]        disp_num;
    logic [DW*PW-1:0]  disp_preg;
    logic [DW*AW-1:0]  disp_areg;
    logic [DW-1:0]     disp_store;
    logic [DW*NB-1:0]  disp_bmask;
    logic              disp_ready;
    logic [IW-1:0]     disp_tag;
    logic              cmp_valid;
    logic [IW-1:0]     cmp_tag;
    logic              br_valid, br_miss;
    logic [1:0]        br_id;
    logic [RW-1:0]     ret_valid;
    logic [RW*PW-1:0]  ret_preg;
    logic [RW*AW-1:0]  ret_areg;
    logic [RW-1:0]     ret_store;
    logic [NPREG-1:0]  flush_free;

    retire_queue uut (
        .clk(clk), .rst_n(rst_n), .disp_num(disp_num), .disp_preg(disp_preg),
        .disp_areg(disp_areg), .disp_store(disp_store), .disp_bmask(disp_bmask),
        .disp_ready(disp_ready), .disp_tag(disp_tag), .cmp_valid(cmp_valid),
        .cmp_tag(cmp_tag), .br_valid(br_valid), .br_miss(br_miss), .br_id(br_id),
        .ret_valid(ret_valid), .ret_preg(ret_preg), .ret_areg(ret_areg),
        .ret_store(ret_store), .flush_free(flush_free)
    );

    typedef struct {
        int tag; int preg; int areg; bit st; int mask; bit done;
    } ent_t;

    ent_t mq[$];
    int   m_head = 0;
    int   m_nret = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   pctr = 0;
    int   brq[$];
    bit   finished = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        disp_num = 0; disp_preg = '0; disp_areg = '0; disp_store = '0; disp_bmask = '0;
        cmp_valid = 0; cmp_tag = '0; br_valid = 0; br_miss = 0; br_id = '0;
    endtask

    task automatic put(input int n, input int mask, input bit st);
        disp_num = 3'(n);
        for (int l = 0; l < DW; l++) begin
            disp_preg[l*PW +: PW]  = PW'(pctr % NPREG);
            disp_areg[l*AW +: AW]  = AW'((pctr * 7 + 3) % 32);
            disp_store[l]          = st ^ l[0];
            disp_bmask[l*NB +: NB] = NB'(mask);
            pctr++;
        end
    endtask

    task automatic cmp(input int tag);
        cmp_valid = 1; cmp_tag = IW'(tag);
    endtask

    // Expected outputs from the model state and the current inputs.
    task automatic compare();
        bit fl;
        int exp_ready, ff;
        fl = br_valid && br_miss;
        exp_ready = (!fl && (DEPTH - mq.size()) >= int'(disp_num)) ? 1 : 0;
        chk("R1 R11", "disp_ready", disp_ready, exp_ready);
        chk("R2", "disp_tag", disp_tag, (m_head + mq.size()) % DEPTH);
        // R4: a masked or incomplete head entry stops the run
        m_nret = 0;
        while (m_nret < RW && m_nret < mq.size() && mq[m_nret].done && mq[m_nret].mask == 0)
            m_nret++;
        chk("R3", "ret_valid", ret_valid, (1 << m_nret) - 1);
        for (int k = 0; k < m_nret; k++) begin
            chk("R5", "ret_preg", ret_preg[k*PW +: PW], mq[k].preg);
            chk("R5", "ret_areg", ret_areg[k*AW +: AW], mq[k].areg);
        end
        for (int k = 0; k < RW; k++)
            chk("R6", "ret_store", ret_store[k], (k < m_nret) ? mq[k].st : 0);
        ff = 0;
        if (fl) foreach (mq[i]) if (mq[i].mask[br_id]) ff |= (1 << mq[i].preg);
        chk("R7", "flush_free", flush_free, ff);
    endtask

    // Advance the model by one clock edge.
    task automatic model_update();
        bit fl, acc;
        int base;
        ent_t e;
        fl   = br_valid && br_miss;
        acc  = disp_num != 0 && !fl && (DEPTH - mq.size()) >= int'(disp_num);
        base = (m_head + mq.size()) % DEPTH;
        repeat (m_nret) void'(mq.pop_front());
        m_head = (m_head + m_nret) % DEPTH;
        if (br_valid) begin
            if (br_miss) begin
                for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].mask[br_id]) mq.delete(i);
            end else begin
                foreach (mq[i]) mq[i].mask &= ~(1 << br_id);
            end
        end
        if (cmp_valid) foreach (mq[i]) if (mq[i].tag == int'(cmp_tag)) mq[i].done = 1;
        if (acc) begin
            for (int l = 0; l < int'(disp_num); l++) begin
                e.tag = (base + l) % DEPTH;
                e.preg = int'(disp_preg[l*PW +: PW]);
                e.areg = int'(disp_areg[l*AW +: AW]);
                e.st = disp_store[l];
                e.mask = int'(disp_bmask[l*NB +: NB]);
                e.done = 0;
                mq.push_back(e);
            end
        end
    endtask

    task automatic tick();
        #2 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    function automatic int active_mask();
        int m = 0;
        foreach (brq[i]) m |= (1 << brq[i]);
        return m;
    endfunction

    function automatic int first_undone();
        foreach (mq[i]) if (!mq[i].done) return i;
        return -1;
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired before the run completed");
            summary();
            $finish;
        end
    end

    initial begin : main
        int exp_tag, k;
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        put(4, 0, 0);
        #1;
        chk("R10", "ready after reset", disp_ready, 1);
        chk("R10", "tag after reset", disp_tag, 0);
        chk("R10", "retire after reset", ret_valid, 0);
        chk("R10", "flush_free after reset", flush_free, 0);
        idle();

        // Fill to 16 entries, then a single-lane group must stall.
        for (int g = 0; g < 4; g++) begin idle(); put(4, 0, g[0]); tick(); end
        idle(); put(1, 0, 0); #1 chk("R1", "ready when full", disp_ready, 0); tick();

        // Retire two entries, then offer 4 into 2 free slots: nothing is taken.
        idle(); cmp(mq[1].tag); tick();
        idle(); cmp(mq[0].tag); tick();
        idle(); tick();
        idle(); put(4, 0, 1); tick();
        idle(); #1 chk("R2", "no partial accept (tail unchanged)", disp_tag, 0);
        put(2, 0, 1); tick();

        // Finish younger entries first; a 4-wide retire appears once the head completes.
        for (int i = 5; i >= 1; i--) begin idle(); cmp(mq[i].tag); tick(); end
        idle(); #1 chk("R3", "stop at incomplete head", ret_valid, 0);
        cmp(mq[0].tag); tick();
        idle(); #1 chk("R3", "four-wide retire", ret_valid, 4'hF);
        for (int c = 0; c < 60 && mq.size() > 0; c++) begin
            idle(); k = first_undone(); if (k >= 0) cmp(mq[k].tag); tick();
        end

        // Speculative entries under branches 0 and 1.
        idle(); put(2, 0, 1); tick();
        idle(); put(4, 1, 0); tick();
        idle(); put(2, 3, 1); tick();
        for (int c = 0; c < 8; c++) begin idle(); k = first_undone(); if (k >= 0) cmp(mq[k].tag); tick(); end
        idle(); tick(); idle(); tick();
        idle(); #1 chk("R4", "masked entries held", ret_valid, 0);
        exp_tag = (m_head + mq.size() - 2) % DEPTH;
        br_valid = 1; br_miss = 1; br_id = 2'd1; put(1, 0, 0);
        #1 chk("R11", "dispatch blocked in flush", disp_ready, 0);
        tick();
        idle(); #1 chk("R7", "tail pulled back", disp_tag, exp_tag);
        br_valid = 1; br_miss = 0; br_id = 2'd0; tick();
        idle(); #1 chk("R8", "cleared entries retire", ret_valid, 4'hF);
        for (int c = 0; c < 10 && mq.size() > 0; c++) begin idle(); tick(); end

        // Completion into an empty slot must not mark a later dispatch.
        idle(); cmp(int'(disp_tag)); tick();
        idle(); put(1, 0, 0); tick();
        idle(); tick();
        idle(); #1 chk("R9", "stale completion ignored", ret_valid, 0);
        cmp(mq[0].tag); tick(); idle(); tick(); idle(); tick();

        // Randomised traffic.
        for (int c = 0; c < 4000; c++) begin
            bit resolving;
            int pick, b, t;
            idle();
            resolving = 0;
            if (brq.size() > 0 && $urandom_range(0, 7) == 0) begin
                pick = $urandom_range(0, brq.size() - 1);
                b = brq[pick];
                br_valid = 1; br_id = 2'(b); br_miss = ($urandom_range(0, 2) == 0);
                resolving = 1;
                if (br_miss) begin
                    while (brq.size() > pick) void'(brq.pop_back());
                end else begin
                    brq.delete(pick);
                end
            end
            if (!resolving && $urandom_range(0, 2) != 0) begin
                if (brq.size() < NB && $urandom_range(0, 4) == 0) begin
                    t = 0;
                    while ((active_mask() >> t) & 1) t++;
                    brq.push_back(t);
                end
                put($urandom_range(1, 4), active_mask(), 1'($urandom_range(0, 1)));
            end
            if (mq.size() > 0 && $urandom_range(0, 3) != 0)
                cmp(mq[$urandom_range(0, mq.size() - 1)].tag);
            else if ($urandom_range(0, 9) == 0)
                cmp($urandom_range(0, DEPTH - 1));
            tick();
        end

        // Drain: resolve all branches correctly and complete everything.
        for (int c = 0; c < 300 && (mq.size() > 0 || brq.size() > 0); c++) begin
            idle();
            if (brq.size() > 0) begin
                br_valid = 1; br_miss = 0; br_id = 2'(brq[0]); brq.delete(0);
            end
            k = first_undone();
            if (k >= 0) cmp(mq[k].tag);
            tick();
        end
        idle(); #1 chk("R3", "drained buffer retires nothing", ret_valid, 0);
        tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule